// File: doc/BRIEF.md
# Indirect Memory and Peripheral Access Window

This block sits on a host register bus and opens two windows into internal state that the host cannot address directly: a word-organised SRAM and a small peripheral register file. Each window has its own read-address, write-address, read-data and write-data registers. The host programs an address register first and then accesses the matching data register as often as it needs.

On the memory window, each completed data access moves the pointer it used forward by one 32-bit word. Streams of reads and streams of writes can therefore run against independent pointers without being reprogrammed. On the peripheral window, the address word carries a register offset and a transfer size. That size selects how many low-order byte lanes a data access touches, and the pointer never moves.

Data-register accesses depend on the internal domain being awake. While it sleeps, they are refused and flagged. Address registers stay usable at all times. The host bus is reduced to a single-cycle request with write select, a 12-bit byte offset and 32-bit data. Every read returns its data one cycle after the request.

Top module: `idxw_top`

## Requirements
- R1: Address registers sit at offsets 0x40C (memory read pointer), 0x410 (memory write pointer), 0x448 (peripheral read pointer) and 0x444 (peripheral write pointer). Reading an address register returns what was loaded. Memory pointers hold all 32 bits. Peripheral pointers keep only bits 15:0 (offset) and bits 25:24 (size) and read zero elsewhere, so loading 0xFFFFFFFF reads back as 0x0300FFFF.
- R2: A write to offset 0x418 stores the data at the memory word selected by the write pointer and then adds 4 to the write pointer. Writes produce no read response.
- R3: A read of offset 0x41C returns the memory word at the read pointer one cycle after the request, with rvalid_o high. The read pointer then reads 4 larger.
- R4: The memory read pointer and write pointer advance independently. An access to one data register leaves the other pointer unchanged.
- R5: A write to offset 0x44C with peripheral write-pointer size s (bits 25:24, the number of bytes minus one) updates byte lanes 0 through s of the selected register. All other lanes keep their old contents.
- R6: A read of offset 0x450 with peripheral read-pointer size s returns byte lanes 0 through s of the selected register and returns zero in the lanes above them.
- R7: Peripheral pointers change only when they are loaded. Data accesses never advance them.
- R8: While awake_i is low, an access to any of the four data registers writes nothing and moves no pointer. A read of a data register returns 0xFFFFFFFF. err_o is high for exactly the cycle in which the response appears.
- R9: Writes and reads of the address registers work normally while awake_i is low and do not raise err_o.
- R10: After reset, all pointers, all memory words and all peripheral registers are zero, and rvalid_o and err_o are low.
- R11: Reads of offsets that are not address or read-data registers return zero. Writes to them have no effect on any pointer or stored word.
- R12: The memory word is selected by pointer bits [log2(MEM_WORDS)+1:2]. Higher pointer bits are ignored, so a pointer that advances past the last word wraps to word 0. The peripheral register is selected the same way, by bits [log2(PRPH_REGS)+1:2] of the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Single-cycle host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| awake_i | input | 1 | Internal domain awake; gates the data registers |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response, one cycle after a read request |
| err_o | output | 1 | One-cycle pulse when a data access is refused |

## Verification
Directed sequences come first. They cover:
- word streams that separate the read pointer from the write pointer;
- a write stream that crosses the top of memory and shows the wrap;
- peripheral writes and reads at each size, which reveal whether lanes above the size are preserved on writes and zeroed on reads;
- a sleep episode, followed by a wake-up read-back, which proves that refused accesses left both the data and the pointers untouched.

A random mix then interleaves pointer loads, data accesses, unmapped offsets and short sleep periods. It is checked against a reference model in the bench, which catches ordering faults between pointer updates and data returns that the directed cases do not reach.

// File: rtl/idxw_pkg.sv
package idxw_pkg;
  localparam int unsigned WIN_AW = 12;
  localparam int unsigned DW     = 32;
  localparam int unsigned NLANE  = DW / 8;

  localparam logic [WIN_AW-1:0] OFF_M_RADDR = 12'h40C;
  localparam logic [WIN_AW-1:0] OFF_M_WADDR = 12'h410;
  localparam logic [WIN_AW-1:0] OFF_M_WDAT  = 12'h418;
  localparam logic [WIN_AW-1:0] OFF_M_RDAT  = 12'h41C;
  localparam logic [WIN_AW-1:0] OFF_P_WADDR = 12'h444;
  localparam logic [WIN_AW-1:0] OFF_P_RADDR = 12'h448;
  localparam logic [WIN_AW-1:0] OFF_P_WDAT  = 12'h44C;
  localparam logic [WIN_AW-1:0] OFF_P_RDAT  = 12'h450;

  // peripheral address word: offset [15:0], size-1 [25:24]
  localparam logic [DW-1:0] P_ADDR_KEEP = 32'h0300_FFFF;
  localparam int unsigned   P_SIZE_LSB  = 24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_M_RADDR,
    SEL_M_WADDR,
    SEL_M_WDAT,
    SEL_M_RDAT,
    SEL_P_WADDR,
    SEL_P_RADDR,
    SEL_P_WDAT,
    SEL_P_RDAT
  } win_sel_e;

  function automatic win_sel_e win_decode(input logic [WIN_AW-1:0] a);
    win_sel_e s;
    case (a)
      OFF_M_RADDR: s = SEL_M_RADDR;
      OFF_M_WADDR: s = SEL_M_WADDR;
      OFF_M_WDAT:  s = SEL_M_WDAT;
      OFF_M_RDAT:  s = SEL_M_RDAT;
      OFF_P_WADDR: s = SEL_P_WADDR;
      OFF_P_RADDR: s = SEL_P_RADDR;
      OFF_P_WDAT:  s = SEL_P_WDAT;
      OFF_P_RDAT:  s = SEL_P_RDAT;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic is_data_sel(input win_sel_e s);
    return (s == SEL_M_WDAT) || (s == SEL_M_RDAT) ||
           (s == SEL_P_WDAT) || (s == SEL_P_RDAT);
  endfunction

  function automatic logic [NLANE-1:0] lane_en(input logic [1:0] sz);
    logic [NLANE-1:0] be;
    for (int i = 0; i < NLANE; i++) be[i] = (i <= int'(sz));
    return be;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [NLANE-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < NLANE; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/idxw_ptr.sv
module idxw_ptr #(
  parameter int unsigned   W    = 32,
  parameter int unsigned   STEP = 4,
  parameter logic [W-1:0]  KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  generate
    if (STEP == 0) begin : g_fixed
      logic unused_step;
      assign unused_step = step_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (load_i) q <= load_val_i & KEEP;
      end
    end else begin : g_step
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (load_i)  q <= load_val_i & KEEP;
        else if (step_i)  q <= q + W'(STEP);
      end
    end
  endgenerate

  assign q_o = q;
endmodule

// File: rtl/idxw_mem.sv
module idxw_mem #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[i] <= '0;
      else if (we_i && (widx_i == IW'(i)))    mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/idxw_prph.sv
module idxw_prph #(
  parameter int unsigned REGS  = 16,
  parameter int unsigned NLANE = 4,
  parameter int unsigned IW    = $clog2(REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      widx_i,
  input  logic [NLANE-1:0]   wbe_i,
  input  logic [NLANE*8-1:0] wdata_i,
  input  logic [IW-1:0]      ridx_i,
  output logic [NLANE*8-1:0] rdata_o
);
  logic [NLANE-1:0][7:0] reg_q [REGS];

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    for (genvar b = 0; b < NLANE; b++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          reg_q[r][b] <= '0;
        else if (we_i && wbe_i[b] && (widx_i == IW'(r)))
          reg_q[r][b] <= wdata_i[b*8 +: 8];
      end
    end
  end

  assign rdata_o = reg_q[ridx_i];
endmodule

// File: rtl/idxw_top.sv
module idxw_top
  import idxw_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64,
  parameter int unsigned PRPH_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              awake_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  localparam int unsigned MIW   = $clog2(MEM_WORDS);
  localparam int unsigned PIW   = $clog2(PRPH_REGS);
  localparam int unsigned WSTEP = DW / 8;

  win_sel_e sel;
  logic rd_req, wr_req, blocked;
  logic m_wr, m_rd, p_wr;
  logic [DW-1:0] m_rptr, m_wptr, p_rptr, p_wptr;
  logic [DW-1:0] mem_rdata, prph_rdata, rd_mux;
  logic [DW-1:0] rdata_q;
  logic rvalid_q, err_q;

  assign sel     = win_decode(addr_i);
  assign rd_req  = req_i && !we_i;
  assign wr_req  = req_i && we_i;
  assign blocked = req_i && is_data_sel(sel) && !awake_i;

  assign m_wr = wr_req && awake_i && (sel == SEL_M_WDAT);
  assign m_rd = rd_req && awake_i && (sel == SEL_M_RDAT);
  assign p_wr = wr_req && awake_i && (sel == SEL_P_WDAT);

  idxw_ptr #(.W(DW), .STEP(WSTEP)) u_m_rptr (
    .clk_i, .rst_ni,
    .load_i(wr_req && (sel == SEL_M_RADDR)), .load_val_i(wdata_i),
    .step_i(m_rd), .q_o(m_rptr)
  );

  idxw_ptr #(.W(DW), .STEP(WSTEP)) u_m_wptr (
    .clk_i, .rst_ni,
    .load_i(wr_req && (sel == SEL_M_WADDR)), .load_val_i(wdata_i),
    .step_i(m_wr), .q_o(m_wptr)
  );

  idxw_ptr #(.W(DW), .STEP(0), .KEEP(P_ADDR_KEEP)) u_p_rptr (
    .clk_i, .rst_ni,
    .load_i(wr_req && (sel == SEL_P_RADDR)), .load_val_i(wdata_i),
    .step_i(1'b0), .q_o(p_rptr)
  );

  idxw_ptr #(.W(DW), .STEP(0), .KEEP(P_ADDR_KEEP)) u_p_wptr (
    .clk_i, .rst_ni,
    .load_i(wr_req && (sel == SEL_P_WADDR)), .load_val_i(wdata_i),
    .step_i(1'b0), .q_o(p_wptr)
  );

  idxw_mem #(.WORDS(MEM_WORDS), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .we_i(m_wr), .widx_i(m_wptr[MIW+1:2]), .wdata_i(wdata_i),
    .ridx_i(m_rptr[MIW+1:2]), .rdata_o(mem_rdata)
  );

  idxw_prph #(.REGS(PRPH_REGS), .NLANE(NLANE)) u_prph (
    .clk_i, .rst_ni,
    .we_i(p_wr), .widx_i(p_wptr[PIW+1:2]),
    .wbe_i(lane_en(p_wptr[P_SIZE_LSB +: 2])), .wdata_i(wdata_i),
    .ridx_i(p_rptr[PIW+1:2]), .rdata_o(prph_rdata)
  );

  always_comb begin
    case (sel)
      SEL_M_RADDR: rd_mux = m_rptr;
      SEL_M_WADDR: rd_mux = m_wptr;
      SEL_M_RDAT:  rd_mux = mem_rdata;
      SEL_P_RADDR: rd_mux = p_rptr;
      SEL_P_WADDR: rd_mux = p_wptr;
      SEL_P_RDAT:  rd_mux = prph_rdata & lane_mask(lane_en(p_rptr[P_SIZE_LSB +: 2]));
      default:     rd_mux = '0;
    endcase
    if (blocked) rd_mux = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      err_q    <= blocked;
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/idxw_chk.sv
module idxw_chk
  import idxw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [WIN_AW-1:0] addr_i,
  input logic              awake_i,
  input logic [DW-1:0]     rdata_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic [DW-1:0]     m_rptr,
  input logic [DW-1:0]     m_wptr,
  input logic [DW-1:0]     p_rptr,
  input logic [DW-1:0]     p_wptr
);
  logic dat_acc, p_load;
  assign dat_acc = req_i && is_data_sel(win_decode(addr_i));
  assign p_load  = req_i && we_i &&
                   ((addr_i == OFF_P_RADDR) || (addr_i == OFF_P_WADDR));

  p_rd_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);

  p_wr_noresp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> !rvalid_o);

  p_mrd_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && awake_i && (addr_i == OFF_M_RDAT)
    |=> (m_rptr == $past(m_rptr) + 32'd4) && $stable(m_wptr));

  p_mwr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && awake_i && (addr_i == OFF_M_WDAT)
    |=> (m_wptr == $past(m_wptr) + 32'd4) && $stable(m_rptr));

  p_sleep_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_acc && !we_i && !awake_i |=> (rdata_o == '1) && err_o);

  p_sleep_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_acc && !awake_i |=> $stable(m_rptr) && $stable(m_wptr));

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(dat_acc && !awake_i));

  p_prph_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_load |=> $stable(p_rptr) && $stable(p_wptr));

  p_prph_zext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && awake_i && (addr_i == OFF_P_RDAT)
    |=> (rdata_o & ~lane_mask(lane_en($past(p_rptr[P_SIZE_LSB +: 2])))) == '0);
endmodule

bind idxw_top idxw_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .awake_i(awake_i), .rdata_o(rdata_o),
  .rvalid_o(rvalid_o), .err_o(err_o),
  .m_rptr(m_rptr), .m_wptr(m_wptr), .p_rptr(p_rptr), .p_wptr(p_wptr)
);

// File: tb/idxw_top_bench.sv
`timescale 1ns/1ps
module idxw_top_bench;
  localparam int MEMW  = 64;
  localparam int PREGS = 16;
  localparam logic [11:0] A_MRA = 12'h40C, A_MWA = 12'h410, A_MWD = 12'h418, A_MRD = 12'h41C;
  localparam logic [11:0] A_PWA = 12'h444, A_PRA = 12'h448, A_PWD = 12'h44C, A_PRD = 12'h450;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, awake = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, err;

  always #2 clk = ~clk;

  idxw_top u_idxw_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .awake_i(awake), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] mm [MEMW];
  logic [31:0] pm [PREGS];
  logic [31:0] mrp = '0, mwp = '0, prp = '0, pwp = '0;
  logic [31:0] last_rd;
  logic last_err;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] s);
    return {{8{s >= 2'd3}}, {8{s >= 2'd2}}, {8{s >= 2'd1}}, 8'hFF};
  endfunction

  function automatic bit isdata(input logic [11:0] a);
    return (a == A_MWD) || (a == A_MRD) || (a == A_PWD) || (a == A_PRD);
  endfunction

  function automatic string tag(input logic [11:0] a);
    case (a)
      A_MRA, A_MWA, A_PRA, A_PWA: return "R1";
      A_MRD: return "R3";
      A_PRD: return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      A_MRA: return mrp;
      A_MWA: return mwp;
      A_MRD: return mm[mrp[7:2]];
      A_PRA: return prp;
      A_PWA: return pwp;
      A_PRD: return pm[prp[5:2]] & msk(prp[25:24]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic op(input logic [11:0] a, input bit w, input logic [31:0] d);
    logic [31:0] e_rd;
    bit e_err;
    e_err = isdata(a) && !awake;
    e_rd  = e_err ? 32'hFFFF_FFFF : exp_read(a);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    last_rd  = rdata;
    last_err = err;
    chk(w ? "R2 rvalid" : "R3 rvalid", {31'b0, rvalid}, {31'b0, !w});
    chk(e_err ? "R8 err" : "R9 err", {31'b0, err}, {31'b0, e_err});
    if (!w) chk(e_err ? "R8 rdata" : tag(a), rdata, e_rd);
    if (w) begin
      case (a)
        A_MRA: mrp = d;
        A_MWA: mwp = d;
        A_PRA: prp = d & 32'h0300_FFFF;
        A_PWA: pwp = d & 32'h0300_FFFF;
        A_MWD: if (awake) begin mm[mwp[7:2]] = d; mwp += 32'd4; end
        A_PWD: if (awake) pm[pwp[5:2]] = (pm[pwp[5:2]] & ~msk(pwp[25:24])) | (d & msk(pwp[25:24]));
        default: ;
      endcase
    end else if (a == A_MRD && awake) begin
      mrp += 32'd4;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int i = 0; i < MEMW; i++) mm[i] = '0;
    for (int i = 0; i < PREGS; i++) pm[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rvalid", {31'b0, rvalid}, 32'h0);
    chk("R10 err", {31'b0, err}, 32'h0);
    op(A_MRA, 0, 0); chk("R10 mem rptr", last_rd, 32'h0);
    op(A_PWA, 0, 0); chk("R10 prph wptr", last_rd, 32'h0);
    op(A_MRD, 0, 0); chk("R10 mem word", last_rd, 32'h0);
    op(A_MRA, 1, 32'h0);

    // R2 write stream, R4 independence
    op(A_MWA, 1, 32'h20);
    op(A_MWD, 1, 32'hA000_0001);
    op(A_MWD, 1, 32'hB000_0002);
    op(A_MWD, 1, 32'hC000_0003);
    op(A_MWA, 0, 0); chk("R2 wptr step", last_rd, 32'h2C);
    op(A_MRA, 1, 32'h20);
    op(A_MRD, 0, 0); chk("R3 first word", last_rd, 32'hA000_0001);
    op(A_MRD, 0, 0); chk("R3 second word", last_rd, 32'hB000_0002);
    op(A_MRA, 0, 0); chk("R4 rptr", last_rd, 32'h28);
    op(A_MWA, 0, 0); chk("R4 wptr untouched", last_rd, 32'h2C);

    // R12 wrap past last word
    op(A_MWA, 1, 32'hFC);
    op(A_MWD, 1, 32'h1111_1111);
    op(A_MWD, 1, 32'h2222_2222);
    op(A_MRA, 1, 32'h0);
    op(A_MRD, 0, 0); chk("R12 wrap word0", last_rd, 32'h2222_2222);

    // R1 readback
    op(A_MRA, 1, 32'hDEAD_BEE3);
    op(A_MRA, 0, 0); chk("R1 full pointer", last_rd, 32'hDEAD_BEE3);
    op(A_PWA, 1, 32'hFFFF_FFFF);
    op(A_PWA, 0, 0); chk("R1 prph mask", last_rd, 32'h0300_FFFF);

    // R5/R6/R7 byte lanes
    op(A_PWA, 1, 32'h0300_0008);
    op(A_PWD, 1, 32'h1122_3344);
    op(A_PWA, 1, 32'h0000_0008);
    op(A_PWD, 1, 32'hAABB_CCDD);
    op(A_PRA, 1, 32'h0300_0008);
    op(A_PRD, 0, 0); chk("R5 partial write", last_rd, 32'h1122_33DD);
    op(A_PRA, 1, 32'h0100_0008);
    op(A_PRD, 0, 0); chk("R6 two lanes", last_rd, 32'h0000_33DD);
    op(A_PRD, 0, 0); chk("R6 repeat", last_rd, 32'h0000_33DD);
    op(A_PRA, 0, 0); chk("R7 rptr fixed", last_rd, 32'h0100_0008);
    op(A_PWA, 0, 0); chk("R7 wptr fixed", last_rd, 32'h0000_0008);
    op(A_PRA, 1, 32'h0200_0008);
    op(A_PRD, 0, 0); chk("R6 three lanes", last_rd, 32'h0022_33DD);

    // R8/R9 sleep
    awake = 1'b0;
    op(A_MWA, 1, 32'h40);
    chk("R9 no err", {31'b0, last_err}, 32'h0);
    op(A_MWD, 1, 32'h5555_5555);
    chk("R8 err on write", {31'b0, last_err}, 32'h1);
    op(A_MRD, 0, 0); chk("R8 all ones", last_rd, 32'hFFFF_FFFF);
    op(A_MWA, 0, 0); chk("R9 wptr readable, R8 unmoved", last_rd, 32'h40);
    awake = 1'b1;
    op(A_MRA, 1, 32'h40);
    op(A_MRD, 0, 0); chk("R8 nothing written", last_rd, 32'h0);

    // R11 unmapped
    op(12'h400, 1, 32'hFFFF_FFFF);
    op(12'h404, 0, 0); chk("R11 unmapped read", last_rd, 32'h0);
    op(A_MWD - 12'h0, 0, 0); chk("R11 wdata reg reads zero", last_rd, 32'h0);
    op(A_MWA, 0, 0);

    // random mix against model
    for (int n = 0; n < 800; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int k;
      k = $urandom_range(0, 10);
      case (k)
        0: a = A_MRA; 1: a = A_MWA; 2: a = A_PRA; 3: a = A_PWA;
        4: a = A_MWD; 5: a = A_MRD; 6: a = A_PWD; 7: a = A_PRD;
        8: a = 12'h400 + 12'($urandom_range(0, 63) * 4);
        default: a = ($urandom_range(0, 1) != 0) ? A_MRD : A_MWD;
      endcase
      d = $urandom;
      awake = ($urandom_range(0, 9) != 0);
      op(a, $urandom_range(0, 1) != 0, d);
    end
    awake = 1'b1;
    op(A_MRA, 0, 0);
    op(A_MWA, 0, 0);
    op(A_PRA, 0, 0);
    op(A_PWA, 0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end
endmodule